// File: doc/BRIEF.md
# Serial fuse-word programming sequencer

This block burns one fuse word for each command it accepts. It first takes a read strobe of the addressed word and removes from the new data every bit that is already blown. The result goes into a shift register. That register is then walked from the least significant bit upward, one bit position per step. A position holding 1 gets a program strobe of programmed length. A position holding 0 gets only the setup and gap spacing.

After the last position the block takes a closing read strobe. It then pulses `done` and drops `busy`. A quiet hold-off follows, and no new command is taken until it ends. All phase lengths come from a 32-bit timing word that is captured when the command is accepted.

Commands arrive over a valid/ready handshake. `cmd_ready` is high only while the sequencer is idle, and a command transfers on a cycle where `cmd_valid` and `cmd_ready` are both high. This is not a buffered stream. A command offered while `cmd_ready` is low is dropped rather than held, and the block reports it on `ovl_err`, so a sender that sees back-pressure should withdraw its request. The fuse side is plain control: an address, a bit index, a program strobe, a read strobe, and the addressed word read back.

Top module: `fuse_prog_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fuse_prog`, `fuse_rd` and `ovl_err` are 0 and `cmd_ready` is 1.
- R2: A command transfers when `cmd_valid` and `cmd_ready` are both high at a clock edge. `busy` is high from the next cycle until the operation ends, and it is never high together with `cmd_ready`.
- R3: The operation opens with `fuse_rd` high for RD+1 cycles. The bits strobed are exactly `cmd_data & ~fuse_rdata`. No already-blown bit is ever strobed, and the fuse word ends as old OR data.
- R4: Bit positions are visited 0 to 31 in increasing order. The data shifts right with zero fill, so after the 32nd step the shift register is empty. A 0 position gets no strobe.
- R5: Each program strobe holds `fuse_prog` high for PROG+1 consecutive cycles at one unchanged `fuse_bit`.
- R6: Each bit position gets a setup phase and a gap phase of RELAX+1 cycles each, and RELAX=0 is legal. The number of busy cycles is 2(RD+1) + 64(RELAX+1) + n(PROG+1), where n is the count of 1s in the masked data.
- R7: After the last position, `fuse_rd` is high for another RD+1 cycles. Over one operation, `fuse_rd` is high for 2(RD+1) cycles in total, and it is never high together with `fuse_prog`.
- R8: `done` is a one-cycle pulse in the cycle right after `busy` falls. There is exactly one pulse per operation.
- R9: After the `done` cycle, `cmd_ready` stays low for HOLD_CYC further cycles and then returns high.
- R10: `cmd_valid` high while `cmd_ready` is low raises `ovl_err` for one cycle on the next cycle. The offered command is dropped and has no effect on the fuses.
- R11: The timing word fields are PROG in bits [11:0], RELAX in bits [15:12] and RD in bits [21:16]. They are sampled at acceptance, and later changes to `tmg_word` have no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle; a command can be taken |
| cmd_addr | input | ADDR_W | Fuse word address |
| cmd_data | input | WORD_W | Bits to program (1 = burn) |
| tmg_word | input | 32 | Timing fields PROG, RELAX, RD |
| fuse_addr | output | ADDR_W | Word address held for the operation |
| fuse_bit | output | BIT_W | Bit position being handled |
| fuse_prog | output | 1 | Program strobe for `fuse_bit` |
| fuse_rd | output | 1 | Read strobe |
| fuse_rdata | input | WORD_W | Current contents of the addressed word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ovl_err | output | 1 | Command offered while not ready |

## Verification
The assertions assume that `fuse_rdata` always shows the addressed word as it is right now. In particular, a bit reads 0 until its first strobe cycle has passed, and a strobe can only set bits. The bench's fuse model is a register array that is read combinationally at `fuse_addr` and sets the addressed bit at the end of every strobe cycle, which is exactly that contract. Stimulus changes `cmd_*` and `tmg_word` only at falling edges. It offers commands either when `cmd_ready` is high, or as deliberate one-cycle overlap pulses while the block is busy.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RDBK, S_SETUP, S_STRB, S_GAP, S_VRFY, S_DONE, S_QUIET
  } fps_state_e;

  localparam int PROG_LSB = 0;
  localparam int PROG_W   = 12;
  localparam int RLX_LSB  = 12;
  localparam int RLX_W    = 4;
  localparam int RD_LSB   = 16;
  localparam int RD_W     = 6;
endpackage

// File: rtl/fps_timer.sv
module fps_timer #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/fps_shreg.sv
module fps_shreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         shift,
  output logic         lsb,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= '0;
    else if (load)  word <= ld_val;
    else if (shift) word <= {1'b0, word[W-1:1]};
  end

  assign lsb = word[0];
endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
  import fps_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int WORD_W   = 32,
  parameter int HOLD_CYC = 500,
  parameter int BIT_W    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic [31:0]       tmg_word,
  output logic [ADDR_W-1:0] fuse_addr,
  output logic [BIT_W-1:0]  fuse_bit,
  output logic              fuse_prog,
  output logic              fuse_rd,
  input  logic [WORD_W-1:0] fuse_rdata,
  output logic              busy,
  output logic              done,
  output logic              ovl_err
);
  localparam int HOLD_W = $clog2(HOLD_CYC) + 1;
  localparam int CNT_W  = (HOLD_W > PROG_W) ? HOLD_W : PROG_W;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  fps_state_e state, nxt;

  logic [PROG_W-1:0] t_prog;
  logic [RLX_W-1:0]  t_rlx;
  logic [RD_W-1:0]   t_rd;
  logic [WORD_W-1:0] lat_data;
  logic [BIT_W-1:0]  bitcnt;

  logic             tm_ld, tm_exp;
  logic [CNT_W-1:0] tm_val;
  logic             sh_ld, sh_sh, sh_lsb;
  logic [WORD_W-1:0] sh_word;

  fps_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_ld), .val(tm_val), .expired(tm_exp)
  );

  fps_shreg #(.W(WORD_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(sh_ld), .ld_val(lat_data & ~fuse_rdata),
    .shift(sh_sh), .lsb(sh_lsb), .word(sh_word)
  );

  always_comb begin
    nxt    = state;
    tm_ld  = 1'b0;
    tm_val = '0;
    sh_ld  = 1'b0;
    sh_sh  = 1'b0;
    unique case (state)
      S_IDLE: if (cmd_valid) begin
        nxt    = S_RDBK;
        tm_ld  = 1'b1;
        tm_val = CNT_W'(tmg_word[RD_LSB +: RD_W]);
      end
      S_RDBK: if (tm_exp) begin
        sh_ld  = 1'b1;
        nxt    = S_SETUP;
        tm_ld  = 1'b1;
        tm_val = CNT_W'(t_rlx);
      end
      S_SETUP: if (tm_exp) begin
        tm_ld = 1'b1;
        if (sh_lsb) begin
          nxt    = S_STRB;
          tm_val = CNT_W'(t_prog);
        end else begin
          nxt    = S_GAP;
          tm_val = CNT_W'(t_rlx);
        end
      end
      S_STRB: if (tm_exp) begin
        nxt    = S_GAP;
        tm_ld  = 1'b1;
        tm_val = CNT_W'(t_rlx);
      end
      S_GAP: if (tm_exp) begin
        sh_sh = 1'b1;
        tm_ld = 1'b1;
        if (bitcnt == LAST_BIT) begin
          nxt    = S_VRFY;
          tm_val = CNT_W'(t_rd);
        end else begin
          nxt    = S_SETUP;
          tm_val = CNT_W'(t_rlx);
        end
      end
      S_VRFY: if (tm_exp) nxt = S_DONE;
      S_DONE: begin
        nxt    = S_QUIET;
        tm_ld  = 1'b1;
        tm_val = CNT_W'(HOLD_CYC - 1);
      end
      S_QUIET: if (tm_exp) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      t_prog   <= '0;
      t_rlx    <= '0;
      t_rd     <= '0;
      lat_data <= '0;
      fuse_addr <= '0;
      bitcnt   <= '0;
      ovl_err  <= 1'b0;
    end else begin
      state   <= nxt;
      ovl_err <= cmd_valid && (state != S_IDLE);
      if (state == S_IDLE && cmd_valid) begin
        t_prog    <= tmg_word[PROG_LSB +: PROG_W];
        t_rlx     <= tmg_word[RLX_LSB +: RLX_W];
        t_rd      <= tmg_word[RD_LSB +: RD_W];
        lat_data  <= cmd_data;
        fuse_addr <= cmd_addr;
        bitcnt    <= '0;
      end else if (state == S_GAP && tm_exp && bitcnt != LAST_BIT) begin
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end

  assign cmd_ready = (state == S_IDLE);
  assign fuse_bit  = bitcnt;
  assign fuse_prog = (state == S_STRB);
  assign fuse_rd   = (state == S_RDBK) || (state == S_VRFY);
  assign busy      = (state == S_RDBK) || (state == S_SETUP) || (state == S_STRB) ||
                     (state == S_GAP)  || (state == S_VRFY);
  assign done      = (state == S_DONE);
endmodule

// File: rtl/fuse_prog_seq_chk.sv
module fuse_prog_seq_chk
  import fps_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BIT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [BIT_W-1:0]  fuse_bit,
  input logic              fuse_prog,
  input logic              fuse_rd,
  input logic [WORD_W-1:0] fuse_rdata,
  input logic              busy,
  input logic              done,
  input logic              ovl_err,
  input fps_state_e        state,
  input logic [WORD_W-1:0] sh_word
);
  // R2
  ready_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && cmd_ready));

  // R3
  no_reburn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fuse_prog) |-> !fuse_rdata[fuse_bit]);

  // R4
  shift_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_VRFY) |-> (sh_word == '0));

  // R5
  strobe_bit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_prog && $past(fuse_prog)) |-> $stable(fuse_bit));

  // R5
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_prog |-> busy);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fuse_prog && fuse_rd));

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  ovl_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_err |-> $past(cmd_valid && !cmd_ready));
endmodule

bind fuse_prog_seq fuse_prog_seq_chk #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .fuse_bit(fuse_bit), .fuse_prog(fuse_prog), .fuse_rd(fuse_rd),
  .fuse_rdata(fuse_rdata), .busy(busy), .done(done), .ovl_err(ovl_err),
  .state(state), .sh_word(sh_word)
);

// File: tb/fuse_prog_seq_tb.sv
module fuse_prog_seq_tb;
  localparam int ADDR_W = 2;
  localparam int WORD_W = 32;
  localparam int HOLD   = 5;
  localparam int BIT_W  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [WORD_W-1:0] cmd_data = '0;
  logic [31:0]       tmg_word = '0;
  logic [ADDR_W-1:0] fuse_addr;
  logic [BIT_W-1:0]  fuse_bit;
  logic              fuse_prog, fuse_rd, busy, done, ovl_err;
  logic [WORD_W-1:0] fuse_rdata;
  logic [WORD_W-1:0] fmem [4];

  fuse_prog_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .tmg_word(tmg_word),
    .fuse_addr(fuse_addr), .fuse_bit(fuse_bit), .fuse_prog(fuse_prog),
    .fuse_rd(fuse_rd), .fuse_rdata(fuse_rdata), .busy(busy), .done(done),
    .ovl_err(ovl_err)
  );

  // behavioural fuse array: a strobe cycle blows the addressed bit
  assign fuse_rdata = fmem[fuse_addr];
  always_ff @(posedge clk) if (fuse_prog) fmem[fuse_addr][fuse_bit] <= 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor counters, sampled at falling edges
  int busy_c, prog_c, rise_c, rd_c, done_c, ovl_c, q_c, reburn, order_bad, last_bit;
  logic prev_prog, q_act, q_end;

  task automatic clr_mon();
    busy_c = 0; prog_c = 0; rise_c = 0; rd_c = 0; done_c = 0; ovl_c = 0;
    q_c = 0; reburn = 0; order_bad = 0; last_bit = -1; q_act = 0; q_end = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_c++;
      if (fuse_prog) prog_c++;
      if (fuse_rd) rd_c++;
      if (ovl_err) ovl_c++;
      if (fuse_prog && !prev_prog) begin
        rise_c++;
        if (fuse_rdata[fuse_bit]) reburn++;
        if (int'(fuse_bit) <= last_bit) order_bad++;
        last_bit = int'(fuse_bit);
      end
      if (done) begin
        done_c++; q_act = 1; q_c = 0;
      end else if (q_act) begin
        if (cmd_ready) begin q_act = 0; q_end = 1; end
        else q_c++;
      end
    end
    prev_prog = fuse_prog;
  end

  task automatic do_op(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                       input int prog, input int rlx, input int rd, input int ovl_at);
    logic [31:0] old, tw;
    int n1, exp_busy;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    clr_mon();
    old = fmem[a];
    n1 = $countones(d & ~old);
    exp_busy = 2*(rd+1) + 64*(rlx+1) + n1*(prog+1);
    tw = 32'(prog) | (32'(rlx) << 12) | (32'(rd) << 16);
    cmd_addr = a; cmd_data = d; tmg_word = tw; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    tmg_word = ~tw;                                // R11: late change ignored
    cmd_data = ~d;
    if (ovl_at > 0) begin
      repeat (ovl_at) @(negedge clk);
      cmd_addr = a; cmd_data = 32'hFFFF_FFFF; cmd_valid = 1'b1;   // R10 overlap
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (!q_end) @(negedge clk);
    check("R6 busy cycles", busy_c, exp_busy);
    check("R11 busy cycles under late timing change", busy_c, exp_busy);
    check("R3 strobe count", rise_c, n1);
    check("R3 no reburn", reburn, 0);
    check("R5 strobe cycles", prog_c, n1*(prog+1));
    check("R7 read cycles", rd_c, 2*(rd+1));
    check("R4 bit order", order_bad, 0);
    check("R3 fuse word", fmem[a], old | d);
    check("R8 done pulses", done_c, 1);
    check("R9 quiet cycles", q_c, HOLD);
    check("R10 overlap pulses", ovl_c, (ovl_at > 0) ? 1 : 0);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    int k;
    fmem[0] = 32'h0000_F00F; fmem[1] = 32'h8000_0001; fmem[2] = '0; fmem[3] = 32'h5555_0000;
    prev_prog = 1'b0;
    clr_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 prog", fuse_prog, 0);
    check("R1 rd", fuse_rd, 0);
    check("R1 ovl_err", ovl_err, 0);
    check("R1 ready", cmd_ready, 1);

    k = 0;
    foreach (fmem[i]) begin end
    for (int rlx = 0; rlx < 4; rlx += 3) begin
      for (int prog = 0; prog < 4; prog += 3) begin
        for (int rd = 0; rd < 3; rd += 2) begin
          for (int p = 0; p < 3; p++) begin
            logic [31:0] d;
            case (p)
              0: d = 32'hA5C3_0F96 ^ (32'(k) * 32'h0101_0101);
              1: d = (k % 2 == 0) ? 32'hFFFF_FFFF : 32'h0000_0000;
              default: d = 32'h1 << (k % 32);
            endcase
            do_op(ADDR_W'(k % 4), d, prog, rlx, rd, (p == 0) ? 7 : 0);
            k++;
          end
        end
      end
    end
    // RELAX=1 with a longer strobe on a fresh pattern
    do_op(2'd2, 32'h8001_0240, 5, 1, 1, 0);

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule